// File: doc/BRIEF.md
# Video Processor DMA Sequencer

This block runs the DMA engine of a tile-based video display processor. Software programs a small set of DMA registers: mode, auto-increment, a 16-bit word count, a source address and the operation select. It then issues a command whose code bits say whether a DMA is wanted and where the words go. When the code and the enable bit agree, the sequencer starts one of three transfers:

- **External-bus copy.** Words are read over the CPU bus. The CPU is held off that bus for the whole run.
- **Fill.** One word, taken from the next data-port write, is written repeatedly.
- **Video RAM copy.** Words are copied from one place in video RAM to another.

Each word goes out on a memory write stream. The stream is tagged with its target memory: VRAM, CRAM or VSRAM.

Both read streams and the write stream use valid/ready handshakes:

- **CPU-bus read (`rd_*`).** `rd_valid` stays high with a stable `rd_addr` until `rd_ready` is seen. `rd_data` is taken in the cycle where both are high.
- **Video RAM read (`vr_*`).** The same rules apply to `vr_valid`, `vr_addr`, `vr_ready` and `vr_data`.
- **Memory write (`mw_*`).** `mw_valid` stays high with stable address, data and target until `mw_ready` is high. No beat is lost or repeated under back-pressure.

The count and source registers are left at their advanced values when a run ends. A second DMA can therefore continue where the first stopped.

Top module: `vdp_dma_ctrl`

## Requirements
- R1: A DMA starts only on a command write with code bit 5 set while mode register 1 bit 4 (DMA enable) is 1. Otherwise `busy` stays 0 and no beat is issued.
- R2: Register 23 selects the operation:
  - bit 7 = 0 is an external-bus copy, and bit 6 is then source byte-address bit 23;
  - bits 7:6 = 10 is a fill;
  - bits 7:6 = 11 is a video RAM copy.
- R3: The code is valid only under all of these conditions:
  - code bit 0 is 1;
  - code bits 3:1 are 000 (VRAM, tag 0), 001 (CRAM, tag 1) or 010 (VSRAM, tag 2);
  - code bit 4 is 1 exactly when the operation is a video RAM copy;
  - a video RAM copy targets VRAM only.
  An invalid code starts nothing and costs no cycles.
- R4: The word count is {reg20, reg19}. A count of 0 transfers 65536 words.
- R5: The external-bus source word address is {reg23[6:0], reg22, reg21}. `rd_addr` carries it as a byte address, shifted left by one (0x7F, 0x87, 0xCF gives 0xFF0F9E).
- R6: During an external-bus copy, `bus_req` is high from the cycle after the trigger until the last write beat is accepted. `rd_valid` is raised only while `bus_grant` is high.
- R7: The count decrements and the 16-bit source low part {reg22, reg21} increments by one per word, wrapping within its 16 bits. Reg23 is never changed. Both keep their final values, so a new command with no rewrites continues from them.
- R8: The destination starts at `cmd_addr` and advances by reg15 after every word, wrapping at 16 bits.
- R9: A fill writes nothing until the next `data_wr_en`. That word is then written to every destination.
- R10: `busy` rises in the cycle after the trigger and falls after the last write beat is accepted.
- R11: On all streams the payload holds steady until the handshake completes.
- R12: Register writes made while `busy` is high are ignored.
- R13: A video RAM copy reads words from `vr_addr` = {reg22, reg21}, advancing per R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_idx | input | 5 | Register index |
| reg_wr_data | input | 8 | Register write value |
| cmd_valid | input | 1 | Command write strobe |
| cmd_code | input | 6 | Command code bits |
| cmd_addr | input | 16 | Destination start address |
| data_wr_en | input | 1 | Data port write strobe |
| data_wr_word | input | 16 | Data port write value |
| bus_req | output | 1 | CPU bus request |
| bus_grant | input | 1 | CPU bus grant |
| rd_valid | output | 1 | CPU-bus read request valid |
| rd_ready | input | 1 | CPU-bus read accepted, data present |
| rd_addr | output | 24 | CPU-bus byte address |
| rd_data | input | 16 | CPU-bus read data |
| vr_valid | output | 1 | Video RAM read valid |
| vr_ready | input | 1 | Video RAM read accepted, data present |
| vr_addr | output | 16 | Video RAM read address |
| vr_data | input | 16 | Video RAM read data |
| mw_valid | output | 1 | Memory write valid |
| mw_ready | input | 1 | Memory write accepted |
| mw_target | output | 2 | 0 VRAM, 1 CRAM, 2 VSRAM |
| mw_addr | output | 16 | Memory write address |
| mw_data | output | 16 | Memory write data |
| busy | output | 1 | DMA in progress |

## Verification
The bench targets these corner cases:

- **Zero count.** A design that took a count of zero literally would write nothing instead of 65536 words.
- **Source wrap.** A carry out of the 16-bit source low part would corrupt register 23 and send reads to the wrong 128 KB window.
- **Continuation.** A design that reloaded or cleared the count and source registers would restart from the old address.
- **Rejected codes.** Each malformed code is checked, since accepting one would raise `busy` or write to a memory that was never selected.
- **Fill start.** A fill that started early would emit stale data.
- **Back-pressure.** A write stream that lost or repeated beats while stalled would show up as wrong addresses or wrong data.

// File: rtl/vdp_dma_pkg.sv
package vdp_dma_pkg;
  typedef enum logic [1:0] {
    DM_BUS  = 2'd0,
    DM_FILL = 2'd1,
    DM_COPY = 2'd2
  } dma_mode_e;

  typedef enum logic [1:0] {
    TG_VRAM  = 2'd0,
    TG_CRAM  = 2'd1,
    TG_VSRAM = 2'd2,
    TG_NONE  = 2'd3
  } dma_tgt_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_GRANT = 3'd1,
    S_FILLW = 3'd2,
    S_READ  = 3'd3,
    S_WRITE = 3'd4
  } seq_state_e;

  localparam int REG_MODE = 1;
  localparam int REG_INC  = 15;
  localparam int REG_LENL = 19;
  localparam int REG_LENH = 20;
  localparam int REG_SRCL = 21;
  localparam int REG_SRCM = 22;
  localparam int REG_SRCH = 23;
  localparam int EN_BIT   = 4;
endpackage

// File: rtl/vdp_dma_regs.sv
module vdp_dma_regs
  import vdp_dma_pkg::*;
#(
  parameter int RW = 8,
  parameter int IW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [RW-1:0]   wr_data,
  input  logic            lock,
  input  logic            step,
  input  logic            src_adv,
  output logic            dma_en,
  output logic [RW-1:0]   inc,
  output logic [2*RW-1:0] len,
  output logic            len_last,
  output logic [2*RW-1:0] src_lo,
  output logic [RW-1:0]   src_hi
);
  localparam int LW = 2 * RW;

  logic [RW-1:0] mode_q, inc_q, src_hi_q;
  logic [LW-1:0] len_q, src_q;
  logic          wr_ok;

  assign wr_ok = wr_en && !lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      inc_q    <= '0;
      len_q    <= '0;
      src_q    <= '0;
      src_hi_q <= '0;
    end else if (step) begin
      len_q <= len_q - 1'b1;
      if (src_adv) src_q <= src_q + 1'b1;
    end else if (wr_ok) begin
      case (int'(wr_idx))
        REG_MODE: mode_q           <= wr_data;
        REG_INC:  inc_q            <= wr_data;
        REG_LENL: len_q[RW-1:0]    <= wr_data;
        REG_LENH: len_q[LW-1:RW]   <= wr_data;
        REG_SRCL: src_q[RW-1:0]    <= wr_data;
        REG_SRCM: src_q[LW-1:RW]   <= wr_data;
        REG_SRCH: src_hi_q         <= wr_data;
        default: ;
      endcase
    end
  end

  assign dma_en   = mode_q[EN_BIT];
  assign inc      = inc_q;
  assign len      = len_q;
  assign len_last = (len_q == LW'(1));
  assign src_lo   = src_q;
  assign src_hi   = src_hi_q;
endmodule

// File: rtl/vdp_dma_decode.sv
module vdp_dma_decode
  import vdp_dma_pkg::*;
(
  input  logic [4:0] code,
  input  logic [1:0] op_bits,
  output dma_mode_e  mode,
  output dma_tgt_e   tgt,
  output logic       code_ok
);
  always_comb begin
    if (!op_bits[1])     mode = DM_BUS;
    else if (!op_bits[0]) mode = DM_FILL;
    else                 mode = DM_COPY;

    case (code[3:1])
      3'b000:  tgt = TG_VRAM;
      3'b001:  tgt = TG_CRAM;
      3'b010:  tgt = TG_VSRAM;
      default: tgt = TG_NONE;
    endcase

    code_ok = code[0]
           && (tgt != TG_NONE)
           && (code[4] == (mode == DM_COPY))
           && ((mode != DM_COPY) || (tgt == TG_VRAM));
  end
endmodule

// File: rtl/vdp_dma_seq.sv
module vdp_dma_seq
  import vdp_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_go,
  input  logic [AW-1:0] cmd_addr,
  input  logic          data_wr_en,
  input  logic [DW-1:0] data_wr_word,
  input  logic          dma_en,
  input  logic          code_ok,
  input  dma_mode_e     dec_mode,
  input  dma_tgt_e      dec_tgt,
  input  logic [RW-1:0] inc,
  input  logic          len_last,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic          rd_valid,
  input  logic          rd_ready,
  input  logic [DW-1:0] rd_data,
  output logic          vr_valid,
  input  logic          vr_ready,
  input  logic [DW-1:0] vr_data,
  output logic          mw_valid,
  input  logic          mw_ready,
  output logic [AW-1:0] mw_addr,
  output logic [DW-1:0] mw_data,
  output logic [1:0]    mw_target,
  output logic          busy,
  output logic          step,
  output logic          src_adv
);
  seq_state_e    st_q;
  dma_mode_e     mode_q;
  dma_tgt_e      tgt_q;
  logic [AW-1:0] dst_q;
  logic [DW-1:0] buf_q;
  logic          trig, rd_hs, vr_hs;

  assign trig     = cmd_valid && cmd_go && dma_en && code_ok && (st_q == S_IDLE);
  assign rd_valid = (st_q == S_READ) && (mode_q == DM_BUS) && bus_grant;
  assign vr_valid = (st_q == S_READ) && (mode_q == DM_COPY);
  assign rd_hs    = rd_valid && rd_ready;
  assign vr_hs    = vr_valid && vr_ready;
  assign mw_valid = (st_q == S_WRITE);
  assign step     = mw_valid && mw_ready;
  assign src_adv  = (mode_q != DM_FILL);
  assign busy     = (st_q != S_IDLE);
  assign bus_req  = busy && (mode_q == DM_BUS);
  assign mw_addr  = dst_q;
  assign mw_data  = buf_q;
  assign mw_target = tgt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      mode_q <= DM_BUS;
      tgt_q  <= TG_VRAM;
      dst_q  <= '0;
      buf_q  <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (trig) begin
          mode_q <= dec_mode;
          tgt_q  <= dec_tgt;
          dst_q  <= cmd_addr;
          case (dec_mode)
            DM_BUS:  st_q <= S_GRANT;
            DM_FILL: st_q <= S_FILLW;
            default: st_q <= S_READ;
          endcase
        end
        S_GRANT: if (bus_grant) st_q <= S_READ;
        S_FILLW: if (data_wr_en) begin
          buf_q <= data_wr_word;
          st_q  <= S_WRITE;
        end
        S_READ: begin
          if (rd_hs) begin
            buf_q <= rd_data;
            st_q  <= S_WRITE;
          end else if (vr_hs) begin
            buf_q <= vr_data;
            st_q  <= S_WRITE;
          end
        end
        S_WRITE: if (mw_ready) begin
          dst_q <= dst_q + AW'(inc);
          if (len_last)                st_q <= S_IDLE;
          else if (mode_q != DM_FILL)  st_q <= S_READ;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vdp_dma_ctrl.sv
module vdp_dma_ctrl
  import vdp_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int RW = 8,
  parameter int IW = 5,
  parameter int BW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic [IW-1:0] reg_wr_idx,
  input  logic [RW-1:0] reg_wr_data,
  input  logic          cmd_valid,
  input  logic [5:0]    cmd_code,
  input  logic [AW-1:0] cmd_addr,
  input  logic          data_wr_en,
  input  logic [DW-1:0] data_wr_word,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [BW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          vr_valid,
  input  logic          vr_ready,
  output logic [AW-1:0] vr_addr,
  input  logic [DW-1:0] vr_data,
  output logic          mw_valid,
  input  logic          mw_ready,
  output logic [1:0]    mw_target,
  output logic [AW-1:0] mw_addr,
  output logic [DW-1:0] mw_data,
  output logic          busy
);
  localparam int LW = 2 * RW;
  localparam int HW = BW - LW - 1;

  logic          dma_en, len_last, step, src_adv, code_ok;
  logic [RW-1:0] inc, src_hi;
  logic [LW-1:0] len, src_lo;
  dma_mode_e     dec_mode;
  dma_tgt_e      dec_tgt;

  vdp_dma_regs #(.RW(RW), .IW(IW)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .wr_idx(reg_wr_idx), .wr_data(reg_wr_data),
    .lock(busy), .step(step), .src_adv(src_adv),
    .dma_en(dma_en), .inc(inc), .len(len), .len_last(len_last),
    .src_lo(src_lo), .src_hi(src_hi)
  );

  vdp_dma_decode dec_i (
    .code(cmd_code[4:0]), .op_bits(src_hi[RW-1:RW-2]),
    .mode(dec_mode), .tgt(dec_tgt), .code_ok(code_ok)
  );

  vdp_dma_seq #(.AW(AW), .DW(DW), .RW(RW)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_go(cmd_code[5]), .cmd_addr(cmd_addr),
    .data_wr_en(data_wr_en), .data_wr_word(data_wr_word),
    .dma_en(dma_en), .code_ok(code_ok), .dec_mode(dec_mode), .dec_tgt(dec_tgt),
    .inc(inc), .len_last(len_last),
    .bus_req(bus_req), .bus_grant(bus_grant),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .vr_valid(vr_valid), .vr_ready(vr_ready), .vr_data(vr_data),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr),
    .mw_data(mw_data), .mw_target(mw_target),
    .busy(busy), .step(step), .src_adv(src_adv)
  );

  // word address {hi[6:0], lo} shown as a byte address
  assign rd_addr = {src_hi[HW-1:0], src_lo, 1'b0};
  assign vr_addr = src_lo[AW-1:0];

  logic unused_len;
  assign unused_len = ^len;
endmodule

// File: rtl/vdp_dma_ctrl_chk.sv
module vdp_dma_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [5:0]  cmd_code,
  input logic        busy,
  input logic        bus_req,
  input logic        bus_grant,
  input logic        rd_valid,
  input logic        vr_valid,
  input logic        mw_valid,
  input logic        mw_ready,
  input logic [15:0] mw_addr,
  input logic [15:0] mw_data,
  input logic [1:0]  mw_target
);
  a_r1_start_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid && cmd_code[5]));

  a_r6_read_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (bus_req && bus_grant));

  a_r6_busreq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !(mw_valid && mw_ready)) |=> bus_req);

  a_r10_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid |-> busy);

  a_r11_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr)
                                 && $stable(mw_data) && $stable(mw_target)));

  a_r3_target_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mw_target));

  a_r13_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && vr_valid));
endmodule

bind vdp_dma_ctrl vdp_dma_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .busy(busy), .bus_req(bus_req), .bus_grant(bus_grant),
  .rd_valid(rd_valid), .vr_valid(vr_valid), .mw_valid(mw_valid),
  .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data),
  .mw_target(mw_target)
);

// File: tb/vdp_dma_ctrl_tb_top.sv
`timescale 1ns/1ps
module vdp_dma_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [4:0]  reg_wr_idx = '0;
  logic [7:0]  reg_wr_data = '0;
  logic        cmd_valid = 1'b0;
  logic [5:0]  cmd_code = '0;
  logic [15:0] cmd_addr = '0;
  logic        data_wr_en = 1'b0;
  logic [15:0] data_wr_word = '0;
  logic        bus_req, rd_valid, vr_valid, mw_valid, busy;
  logic        bus_grant = 1'b0;
  logic        mw_ready = 1'b1;
  logic        rd_ready = 1'b1;
  logic        vr_ready = 1'b1;
  logic [23:0] rd_addr;
  logic [15:0] rd_data, vr_addr, vr_data, mw_addr, mw_data;
  logic [1:0]  mw_target;

  int total = 0, bad = 0;
  int nw = 0, nr = 0;
  logic [15:0] wa [0:15];
  logic [15:0] wd [0:15];
  logic [1:0]  wt [0:15];
  logic [23:0] ra [0:15];
  logic [15:0] last_wa;
  bit saw_busy = 0, saw_req = 0, stall = 0, nogrant_wr = 0;

  always #5 clk = ~clk;

  assign rd_data = rd_addr[16:1] ^ 16'h5A3C;
  assign vr_data = vr_addr * 16'd3 + 16'd1;

  vdp_dma_ctrl dut_i (.*);

  always begin
    @(negedge clk);
    bus_grant = bus_req;
    mw_ready  = stall ? ~mw_ready : 1'b1;
    #1;
    if (mw_valid && mw_ready) begin
      if (nw < 16) begin
        wa[nw] = mw_addr; wd[nw] = mw_data; wt[nw] = mw_target;
      end
      last_wa = mw_addr;
      nw++;
    end
    if (rd_valid && rd_ready) begin
      if (nr < 16) ra[nr] = rd_addr;
      nr++;
    end
    if (busy) saw_busy = 1;
    if (bus_req) saw_req = 1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input int idx, input logic [7:0] v);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_idx = 5'(idx); reg_wr_data = v;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic cmd(input logic [5:0] c, input logic [15:0] a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = c; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic dwr(input logic [15:0] v);
    @(negedge clk);
    data_wr_en = 1'b1; data_wr_word = v;
    @(negedge clk);
    data_wr_en = 1'b0;
  endtask

  task automatic clr();
    nw = 0; nr = 0; saw_busy = 0; saw_req = 0;
  endtask

  task automatic wait_idle(input int lim);
    int n = 0;
    while (busy && n < lim) begin
      @(negedge clk);
      n++;
    end
    chk(!busy, "R10 completion", busy, 0);
  endtask

  function automatic logic [15:0] fbus(input logic [23:0] a);
    return a[16:1] ^ 16'h5A3C;
  endfunction

  task automatic t_reset();
    chk(!busy && !bus_req && !mw_valid, "R10 reset idle", {busy, bus_req, mw_valid}, 0);
  endtask

  task automatic t_bus();
    clr();
    stall = 1;
    wreg(1, 8'h10); wreg(15, 8'h02);
    wreg(19, 8'h03); wreg(20, 8'h00);
    wreg(21, 8'hCF); wreg(22, 8'h87); wreg(23, 8'h7F);
    cmd(6'b100001, 16'h1000);
    chk(busy, "R10 busy after trigger", busy, 1);
    wait_idle(200);
    stall = 0;
    chk(nw == 3, "R2 bus copy count", nw, 3);
    chk(saw_req, "R6 bus request seen", saw_req, 1);
    chk(!bus_req, "R6 request released", bus_req, 0);
    for (int i = 0; i < 3; i++) begin
      logic [23:0] ea = 24'hFF0F9E + 24'(2 * i);
      chk(ra[i] == ea, "R5 source byte address", ra[i], ea);
      chk(wa[i] == 16'(16'h1000 + 2 * i), "R8 dest advance", wa[i], 16'h1000 + 2 * i);
      chk(wd[i] == fbus(ea), "R11 data under stall", wd[i], fbus(ea));
      chk(wt[i] == 2'd0, "R3 VRAM tag", wt[i], 0);
    end
  endtask

  task automatic t_continue();
    clr();
    wreg(19, 8'h02);
    cmd(6'b100011, 16'h2000);
    wait_idle(200);
    chk(nw == 2, "R7 continued count", nw, 2);
    chk(ra[0] == 24'hFF0FA4, "R7 source continues", ra[0], 24'hFF0FA4);
    chk(ra[1] == 24'hFF0FA6, "R7 source continues 2", ra[1], 24'hFF0FA6);
    chk(wt[0] == 2'd1, "R3 CRAM tag", wt[0], 1);
  endtask

  task automatic t_wrap();
    clr();
    wreg(15, 8'h04); wreg(19, 8'h02); wreg(20, 8'h00);
    wreg(21, 8'hFF); wreg(22, 8'hFF); wreg(23, 8'h01);
    cmd(6'b100101, 16'hFFFE);
    wait_idle(200);
    chk(ra[0] == 24'h03FFFE, "R7 wrap start", ra[0], 24'h03FFFE);
    chk(ra[1] == 24'h020000, "R7 low part wraps, reg23 kept", ra[1], 24'h020000);
    chk(wa[1] == 16'h0002, "R8 dest wraps", wa[1], 16'h0002);
    chk(wt[0] == 2'd2, "R3 VSRAM tag", wt[0], 2);
  endtask

  task automatic t_fill();
    clr();
    wreg(15, 8'h01); wreg(19, 8'h04); wreg(20, 8'h00); wreg(23, 8'h80);
    cmd(6'b100101, 16'h0010);
    wreg(15, 8'h07);
    repeat (4) @(negedge clk);
    chk(busy && nw == 0, "R9 fill waits for data", nw, 0);
    chk(!saw_req, "R6 no bus request on fill", saw_req, 0);
    dwr(16'hBEEF);
    wait_idle(200);
    chk(nw == 4, "R9 fill count", nw, 4);
    for (int i = 0; i < 4; i++) begin
      chk(wd[i] == 16'hBEEF, "R9 fill value", wd[i], 16'hBEEF);
      chk(wa[i] == 16'(16'h0010 + i), "R12 busy write ignored", wa[i], 16'h0010 + i);
    end
  endtask

  task automatic t_copy();
    clr();
    wreg(15, 8'h01); wreg(19, 8'h03); wreg(20, 8'h00);
    wreg(21, 8'h40); wreg(22, 8'h00); wreg(23, 8'hC0);
    cmd(6'b110001, 16'h0300);
    wait_idle(200);
    chk(nw == 3, "R13 copy count", nw, 3);
    for (int i = 0; i < 3; i++) begin
      logic [15:0] ed = 16'((16'h40 + i) * 3 + 1);
      chk(wd[i] == ed, "R13 copy data", wd[i], ed);
      chk(wa[i] == 16'(16'h0300 + i), "R13 copy dest", wa[i], 16'h0300 + i);
    end
    chk(!saw_req, "R6 no bus request on copy", saw_req, 0);
  endtask

  task automatic t_reject(input logic [7:0] m, input logic [7:0] op,
                          input logic [5:0] c, input string req);
    clr();
    wreg(1, m); wreg(19, 8'h02); wreg(23, op);
    cmd(c, 16'h0);
    repeat (6) @(negedge clk);
    chk(!saw_busy && nw == 0, req, nw, 0);
  endtask

  task automatic t_zero();
    clr();
    wreg(1, 8'h10); wreg(15, 8'h02); wreg(19, 8'h00); wreg(20, 8'h00); wreg(23, 8'h80);
    cmd(6'b100001, 16'h0000);
    dwr(16'h1234);
    wait_idle(70000);
    chk(nw == 65536, "R4 zero count is 65536", nw, 65536);
    chk(last_wa == 16'hFFFE, "R4 last address", last_wa, 16'hFFFE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bus();
    t_continue();
    t_wrap();
    t_fill();
    t_copy();
    t_reject(8'h00, 8'h00, 6'b100001, "R1 enable off");
    t_reject(8'h10, 8'h00, 6'b000001, "R1 code bit 5 clear");
    t_reject(8'h10, 8'h00, 6'b100000, "R3 read code");
    t_reject(8'h10, 8'h00, 6'b110001, "R3 bit 4 on bus copy");
    t_reject(8'h10, 8'hC0, 6'b110011, "R3 copy to CRAM");
    t_reject(8'h10, 8'h80, 6'b101111, "R3 bad target");
    t_reject(8'h10, 8'hC0, 6'b100001, "R3 copy without bit 4");
    t_zero();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule